// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block steps through a small set of debug states as comparator match events arrive. When it first reaches its final state, it can emit a one-cycle trace-start strobe, a one-cycle breakpoint request, or both. The breakpoint request comes with a level that says how the core should act on it: enter background debug mode or run a software interrupt.

Each comparator input is either forced or tagged.
- **Forced:** a match is held as a pending request. The request is taken at the first instruction-boundary strobe after the match.
- **Tagged:** the match pulse itself is ignored. The comparator's tag-hit input moves the sequencer at once, because it marks the instant the tagged instruction reaches execution.

A software trigger bit in the control register jumps straight to the final state, whatever the comparators are doing. Configuration arrives as simple single-cycle register writes. Comparator logic and trace storage sit outside this block.

Top module: `debug_trig_seq`

## Requirements
- R1: After reset the state output reads 0 (disarmed), `traceStart`, `bkptReq` and `bkptSwi` are 0, and all comparators are forced with every select code 00.
- R2: A write to address 0 with bit 0 = 1 moves a disarmed sequencer to state 1 (code 1) on that edge. A write to address 0 with bit 0 = 0 returns any state to 0 and discards a pending forced request. While disarmed, match, tag-hit and boundary inputs have no effect.
- R3: In state 1 or 2, a forced comparator match with a non-zero select code is held pending. The state changes on the edge of the first `instrBoundary` cycle strictly after the match cycle. A boundary in the same cycle as the match does not take it.
- R4: A pending request is taken exactly once. While a request is pending, further matches are ignored. Among simultaneous matches, the lowest comparator index wins.
- R5: The select register for state 1 is at address 2 and the one for state 2 is at address 3. Comparator i uses bits [2i+1:2i], coded 00 = ignore, 01 = state 1, 10 = state 2, 11 = final (code 3).
- R6: Address 1 bit i = 1 makes comparator i tagged. Its match pulses are then ignored, and its tag-hit pulse changes state on that same edge with no boundary needed. A tag hit takes precedence over a pending forced request taken in the same cycle.
- R7: A write to address 0 with bits 0 and 1 both set moves the sequencer to the final state on that edge, from any state, regardless of comparators.
- R8: On entry into the final state, `traceStart` pulses for one cycle if control bit 2 is set, and `bkptReq` pulses for one cycle if control bit 3 is set. Both pulses appear in the first cycle in which the state reads 3. Enable values carried by the same write that triggers take effect.
- R9: `bkptSwi` follows control bit 4: 1 asks for a software interrupt, 0 asks for debug mode entry.
- R10: The final state is left only by a disarm write. Matches, tag hits, boundaries and further trigger writes in the final state change nothing and raise no new pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address |
| wrData | input | 8 | Register write data |
| matchIn | input | 4 | Comparator match pulses |
| tagHitIn | input | 4 | Per-comparator tag hit at execution |
| instrBoundary | input | 1 | Instruction boundary strobe |
| seqState | output | 2 | Current sequencer state |
| traceStart | output | 1 | One-cycle trace start strobe |
| bkptReq | output | 1 | One-cycle breakpoint request |
| bkptSwi | output | 1 | Breakpoint kind: 1 software interrupt, 0 debug mode |

## Verification
The state code is a port, so a wrong state register shows up in the cycle after the edge that corrupted it. A lost or duplicated pending request is less direct: it shows only at the next boundary strobe, as a transition that is missing or one too many. The bench therefore places boundaries both in the match cycle and in later cycles. Wrong entry detection shows as a pulse missing, doubled or misplaced against the first cycle of state 3.

// File: rtl/dts_pkg.sv
package dts_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ONE   = 2'd1,
    SEQ_TWO   = 2'd2,
    SEQ_FINAL = 2'd3
  } seqState_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_TAGM = 2'd1;
  localparam logic [1:0] ADDR_SEL1 = 2'd2;
  localparam logic [1:0] ADDR_SEL2 = 2'd3;

  localparam int CTL_ARM   = 0;
  localparam int CTL_TRIG  = 1;
  localparam int CTL_TRACE = 2;
  localparam int CTL_BKPT  = 3;
  localparam int CTL_SWI   = 4;

  // control -> datapath
  typedef struct packed {
    logic      clearPend;
    seqState_e curState;
  } seqStrb_t;

  // datapath -> control
  typedef struct packed {
    logic      armSet;
    logic      armClr;
    logic      trigHit;
    logic      tagFire;
    seqState_e tagTgt;
    logic      bndFire;
    seqState_e bndTgt;
    logic      traceOn;
    logic      bkptOn;
  } dpEvt_t;
endpackage

// File: rtl/dts_datapath.sv
module dts_datapath
  import dts_pkg::*;
#(
  parameter int NUM_CMP = 4,
  parameter int CFG_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [1:0]          wrAddr,
  input  logic [CFG_W-1:0]    wrData,
  input  logic [NUM_CMP-1:0]  matchIn,
  input  logic [NUM_CMP-1:0]  tagHitIn,
  input  logic                instrBoundary,
  input  seqStrb_t            strb,
  output dpEvt_t              evt,
  output logic                swiMode
);
  localparam int SEL_W = 2 * NUM_CMP;

  logic             traceEnQ, bkptEnQ, swiQ;
  logic [NUM_CMP-1:0] tagModeQ;
  logic [SEL_W-1:0] sel1Q, sel2Q;
  logic             pendQ;
  seqState_e        pendTgtQ;

  logic             ctrlWr;
  logic             armedNow;
  logic [SEL_W-1:0] selNow;
  logic [NUM_CMP-1:0] tagReq, frcReq;
  logic [1:0]       cmpTgt [NUM_CMP];
  logic             anyTag, anyFrc;
  seqState_e        tagTgtSel, frcTgtSel;

  assign ctrlWr   = wrEn && (wrAddr == ADDR_CTRL);
  assign armedNow = (strb.curState == SEQ_ONE) || (strb.curState == SEQ_TWO);
  assign selNow   = (strb.curState == SEQ_TWO) ? sel2Q : sel1Q;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    assign cmpTgt[i] = selNow[2*i +: 2];
    assign tagReq[i] = armedNow && tagModeQ[i] && tagHitIn[i] && (cmpTgt[i] != 2'd0);
    assign frcReq[i] = armedNow && !tagModeQ[i] && matchIn[i] && (cmpTgt[i] != 2'd0);
  end

  // lowest index wins: scan downward so the last hit kept is the lowest
  always_comb begin
    anyTag    = 1'b0;
    anyFrc    = 1'b0;
    tagTgtSel = SEQ_IDLE;
    frcTgtSel = SEQ_IDLE;
    for (int i = NUM_CMP - 1; i >= 0; i--) begin
      if (tagReq[i]) begin
        anyTag    = 1'b1;
        tagTgtSel = seqState_e'(cmpTgt[i]);
      end
      if (frcReq[i]) begin
        anyFrc    = 1'b1;
        frcTgtSel = seqState_e'(cmpTgt[i]);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      traceEnQ <= 1'b0;
      bkptEnQ  <= 1'b0;
      swiQ     <= 1'b0;
      tagModeQ <= '0;
      sel1Q    <= '0;
      sel2Q    <= '0;
    end else if (wrEn) begin
      unique case (wrAddr)
        ADDR_CTRL: begin
          traceEnQ <= wrData[CTL_TRACE];
          bkptEnQ  <= wrData[CTL_BKPT];
          swiQ     <= wrData[CTL_SWI];
        end
        ADDR_TAGM: tagModeQ <= wrData[NUM_CMP-1:0];
        ADDR_SEL1: sel1Q    <= wrData[SEL_W-1:0];
        default:   sel2Q    <= wrData[SEL_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ    <= 1'b0;
      pendTgtQ <= SEQ_IDLE;
    end else if (strb.clearPend) begin
      pendQ    <= 1'b0;
      pendTgtQ <= SEQ_IDLE;
    end else if (!pendQ && anyFrc) begin
      pendQ    <= 1'b1;
      pendTgtQ <= frcTgtSel;
    end
  end

  always_comb begin
    evt.armSet  = ctrlWr && wrData[CTL_ARM];
    evt.armClr  = ctrlWr && !wrData[CTL_ARM];
    evt.trigHit = ctrlWr && wrData[CTL_ARM] && wrData[CTL_TRIG];
    evt.tagFire = anyTag;
    evt.tagTgt  = tagTgtSel;
    evt.bndFire = armedNow && pendQ && instrBoundary;
    evt.bndTgt  = pendTgtQ;
    evt.traceOn = ctrlWr ? wrData[CTL_TRACE] : traceEnQ;
    evt.bkptOn  = ctrlWr ? wrData[CTL_BKPT]  : bkptEnQ;
  end

  assign swiMode = swiQ;
endmodule

// File: rtl/dts_control.sv
module dts_control
  import dts_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  dpEvt_t    evt,
  output seqStrb_t  strb,
  output seqState_e stateQ,
  output logic      traceStart,
  output logic      bkptReq
);
  seqState_e nextState;
  logic      armed;
  logic      moveEvt;
  logic      enterFinal;

  assign armed = (stateQ == SEQ_ONE) || (stateQ == SEQ_TWO);

  always_comb begin
    nextState = stateQ;
    moveEvt   = 1'b0;
    if (evt.armClr) begin
      nextState = SEQ_IDLE;
      moveEvt   = 1'b1;
    end else if (evt.trigHit) begin
      nextState = SEQ_FINAL;
      moveEvt   = 1'b1;
    end else if (evt.armSet && stateQ == SEQ_IDLE) begin
      nextState = SEQ_ONE;
    end else if (armed && evt.tagFire) begin
      nextState = evt.tagTgt;
      moveEvt   = 1'b1;
    end else if (armed && evt.bndFire) begin
      nextState = evt.bndTgt;
      moveEvt   = 1'b1;
    end
  end

  assign enterFinal     = (nextState == SEQ_FINAL) && (stateQ != SEQ_FINAL);
  assign strb.clearPend = moveEvt;
  assign strb.curState  = stateQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= SEQ_IDLE;
      traceStart <= 1'b0;
      bkptReq    <= 1'b0;
    end else begin
      stateQ     <= nextState;
      traceStart <= enterFinal && evt.traceOn;
      bkptReq    <= enterFinal && evt.bkptOn;
    end
  end
endmodule

// File: rtl/debug_trig_seq.sv
module debug_trig_seq
  import dts_pkg::*;
#(
  parameter int NUM_CMP = 4,
  parameter int CFG_W   = (2 * NUM_CMP > 5) ? 2 * NUM_CMP : 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrAddr,
  input  logic [CFG_W-1:0]   wrData,
  input  logic [NUM_CMP-1:0] matchIn,
  input  logic [NUM_CMP-1:0] tagHitIn,
  input  logic               instrBoundary,
  output logic [1:0]         seqState,
  output logic               traceStart,
  output logic               bkptReq,
  output logic               bkptSwi
);
  seqStrb_t  strb;
  dpEvt_t    evt;
  seqState_e stateQ;

  dts_datapath #(.NUM_CMP(NUM_CMP), .CFG_W(CFG_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .matchIn(matchIn), .tagHitIn(tagHitIn), .instrBoundary(instrBoundary),
    .strb(strb), .evt(evt), .swiMode(bkptSwi)
  );

  dts_control u_ctl (
    .clk(clk), .rstN(rstN), .evt(evt), .strb(strb), .stateQ(stateQ),
    .traceStart(traceStart), .bkptReq(bkptReq)
  );

  assign seqState = stateQ;
endmodule

// File: rtl/debug_trig_seq_chk.sv
module debug_trig_seq_chk #(
  parameter int CFG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [1:0]       wrAddr,
  input logic [CFG_W-1:0] wrData,
  input logic [1:0]       seqState,
  input logic             traceStart,
  input logic             bkptReq
);
  logic ctlWr, disarmWr, trigWr;
  assign ctlWr    = wrEn && (wrAddr == 2'd0);
  assign disarmWr = ctlWr && !wrData[0];
  assign trigWr   = ctlWr && wrData[0] && wrData[1];

  a_r2_disarm: assert property (@(posedge clk) disable iff (!rstN)
    disarmWr |=> (seqState == 2'd0));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == 2'd0 && !ctlWr) |=> (seqState == 2'd0));

  a_r7_trig_final: assert property (@(posedge clk) disable iff (!rstN)
    trigWr |=> (seqState == 2'd3));

  a_r8_trace_in_final: assert property (@(posedge clk) disable iff (!rstN)
    traceStart |-> (seqState == 2'd3));

  a_r8_bkpt_entry: assert property (@(posedge clk) disable iff (!rstN)
    bkptReq |-> (seqState == 2'd3 && $past(seqState) != 2'd3));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (traceStart || bkptReq) |=> (!traceStart && !bkptReq));

  a_r10_final_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == 2'd3 && !disarmWr) |=> (seqState == 2'd3));
endmodule

bind debug_trig_seq debug_trig_seq_chk #(.CFG_W(CFG_W)) i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .seqState(seqState), .traceStart(traceStart), .bkptReq(bkptReq)
);

// File: tb/test_debug_trig_seq.sv
`timescale 1ns/1ps
module test_debug_trig_seq;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [3:0] matchIn = '0;
  logic [3:0] tagHitIn = '0;
  logic       instrBoundary = 1'b0;
  logic [1:0] seqState;
  logic       traceStart, bkptReq, bkptSwi;

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  debug_trig_seq i_debug_trig_seq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .matchIn(matchIn), .tagHitIn(tagHitIn), .instrBoundary(instrBoundary),
    .seqState(seqState), .traceStart(traceStart), .bkptReq(bkptReq),
    .bkptSwi(bkptSwi)
  );

  // reference model state, built from the requirements
  bit [1:0] mSt;
  bit       mTr, mBk, mSw, mPend, eTr, eBk;
  bit [3:0] mTag;
  bit [7:0] mS1, mS2;
  bit [1:0] mPT;

  task automatic chk(string req, bit [1:0] st, bit tr, bit bk);
    checks++;
    if (seqState !== st || traceStart !== tr || bkptReq !== bk) begin
      errs++;
      $display("FAIL %s: state/trace/bkpt actual %0d/%0b/%0b expected %0d/%0b/%0b",
               req, seqState, traceStart, bkptReq, st, tr, bk);
    end
  endtask

  task automatic chkSwi(string req, bit exp);
    checks++;
    if (bkptSwi !== exp) begin
      errs++;
      $display("FAIL %s: bkptSwi actual %0b expected %0b", req, bkptSwi, exp);
    end
  endtask

  task automatic tick(bit we, bit [1:0] a, bit [7:0] d, bit [3:0] m, bit [3:0] t,
                      bit b, bit cmp = 1'b0);
    bit cw, aClr, aSet, trg, effTr, effBk, armed, tagF, bnd, clr;
    bit [1:0] tgt, nSt, fTgt;
    bit [7:0] sel;
    bit fFound;
    wrEn = we; wrAddr = a; wrData = d; matchIn = m; tagHitIn = t; instrBoundary = b;
    cw    = we && a == 2'd0;
    aClr  = cw && !d[0];
    aSet  = cw && d[0];
    trg   = aSet && d[1];
    effTr = cw ? d[2] : mTr;
    effBk = cw ? d[3] : mBk;
    armed = (mSt == 2'd1) || (mSt == 2'd2);
    sel   = (mSt == 2'd2) ? mS2 : mS1;
    tagF = 0; tgt = 0; fFound = 0; fTgt = 0;
    for (int i = 0; i < 4; i++) begin
      if (!tagF && mTag[i] && t[i] && sel[2*i +: 2] != 2'd0) begin tagF = 1; tgt = sel[2*i +: 2]; end
      if (!fFound && !mTag[i] && m[i] && sel[2*i +: 2] != 2'd0) begin fFound = 1; fTgt = sel[2*i +: 2]; end
    end
    bnd = armed && mPend && b;
    nSt = mSt; clr = 0;
    if (aClr) begin nSt = 0; clr = 1; end
    else if (trg) begin nSt = 3; clr = 1; end
    else if (aSet && mSt == 0) nSt = 1;
    else if (armed && tagF) begin nSt = tgt; clr = 1; end
    else if (armed && bnd) begin nSt = mPT; clr = 1; end
    @(posedge clk);
    #1;
    eTr = (nSt == 3 && mSt != 3) && effTr;
    eBk = (nSt == 3 && mSt != 3) && effBk;
    if (clr) begin mPend = 0; mPT = 0; end
    else if (!mPend && armed && fFound) begin mPend = 1; mPT = fTgt; end
    mSt = nSt;
    if (we) begin
      case (a)
        2'd0: begin mTr = d[2]; mBk = d[3]; mSw = d[4]; end
        2'd1: mTag = d[3:0];
        2'd2: mS1 = d;
        default: mS2 = d;
      endcase
    end
    if (cmp) begin
      chk("R3/R6 model", mSt, eTr, eBk);
      chkSwi("R9 model", mSw);
    end
  endtask

  task automatic idle(bit [3:0] m = 0, bit [3:0] t = 0, bit b = 0);
    tick(0, 0, 0, m, t, b);
  endtask

  task automatic wr(bit [1:0] a, bit [7:0] d);
    tick(1, a, d, 0, 0, 0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    mSt = 0; mTr = 0; mBk = 0; mSw = 0; mPend = 0; mPT = 0; mTag = 0; mS1 = 0; mS2 = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    chk("R1 reset", 0, 0, 0); chkSwi("R1 reset", 0);

    idle(4'hF, 4'hF, 1); chk("R2 idle ignores events", 0, 0, 0);

    wr(2'd2, 8'h02);           // state1: comp0 -> state2
    wr(2'd3, 8'h1C);           // state2: comp1 -> final, comp2 -> state1
    wr(2'd0, 8'h1D);           // arm + trace + bkpt + swi
    chk("R2 arm", 1, 0, 0); chkSwi("R9 swi", 1);

    idle(4'h1, 0, 1); chk("R3 same-cycle boundary", 1, 0, 0);
    idle();           chk("R3 held", 1, 0, 0);
    idle(0, 0, 1);    chk("R3 taken", 2, 0, 0);
    idle(0, 0, 1);    chk("R4 once", 2, 0, 0);

    idle(4'h6);       chk("R4 pend", 2, 0, 0);
    idle(0, 0, 1);    chk("R4 lowest wins", 3, 1, 1);
    idle();           chk("R8 one cycle", 3, 0, 0);

    wr(2'd0, 8'h1F);  chk("R10 trig in final", 3, 0, 0);
    idle(4'hF, 4'hF, 1); chk("R10 events in final", 3, 0, 0);

    wr(2'd0, 8'h00);  chk("R2 disarm", 0, 0, 0); chkSwi("R9 debug", 0);
    wr(2'd0, 8'h01);  chk("R2 rearm", 1, 0, 0);
    idle(4'h1);       chk("R2 pend set", 1, 0, 0);
    wr(2'd0, 8'h00);  chk("R2 disarm pend", 0, 0, 0);
    wr(2'd0, 8'h01);
    idle(0, 0, 1);    chk("R2 pend cancelled", 1, 0, 0);

    idle(4'h2);
    idle(0, 0, 1);    chk("R5 code 00 ignored", 1, 0, 0);

    wr(2'd1, 8'h08);           // comp3 tagged
    wr(2'd2, 8'hC2);           // comp3 -> final, comp0 -> state2
    idle(4'h8);
    idle(0, 0, 1);    chk("R6 tagged match ignored", 1, 0, 0);
    idle(4'h1);
    idle(0, 4'h8, 1); chk("R6 tag beats pending", 3, 0, 0);

    wr(2'd0, 8'h00);
    wr(2'd0, 8'h09);  chk("R2 arm bkpt only", 1, 0, 0);
    wr(2'd0, 8'h0B);  chk("R7 trig", 3, 0, 1);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h07);  chk("R7 trig from idle", 3, 1, 0);
    wr(2'd0, 8'h00);

    for (int n = 0; n < 4000; n++) begin
      bit we;
      bit [1:0] a;
      bit [7:0] d;
      we = ($urandom % 12) == 0;
      a  = 2'($urandom);
      d  = 8'($urandom);
      if (we && a == 0) begin
        d[0] = ($urandom % 8) != 0;
        d[1] = ($urandom % 6) == 0;
      end
      tick(we, a, d, 4'($urandom) & 4'($urandom) & 4'($urandom),
           4'($urandom) & 4'($urandom) & 4'($urandom), ($urandom % 3) == 0, 1'b1);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule